// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

The block takes one asynchronous serial line and turns it into bytes. The line is assumed to be sampled by a tick enable that runs at sixteen times the baud rate. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The receiver locks its timing onto the falling edge that opens each frame. It then reads every bit at the middle of its bit time, counting ticks from that edge.

The stop bit is checked at its midpoint, and the receiver starts hunting for the next start edge on the tick after that check. It does not wait for the stop bit to finish. A sender whose clock runs a few percent fast, or one that shortens its stop bit, can therefore open the next frame early without losing a byte. Every frame restarts the timing, so clock error only has to stay under half a bit across one ten-bit frame.

For each frame the block outputs the byte, a single-cycle valid pulse and a framing-error flag. Parity, buffering and baud-rate generation sit outside this block.

Top module: `uart_os_rx`

## Requirements
- R1: While rst_n is low at a clock edge, rx_valid, rx_frame_err and rx_data all become 0 at that edge.
- R2: rx_line passes through two clock-edge synchronizer stages before the decoder sees it. A level present at clock edge k is seen by the decoder at edge k+2.
- R3: A frame starts on a tick where the synchronized line is low and it was high at the previous tick (a falling edge). That tick is tick 0, and all later sample points are counted in ticks from it.
- R4: At tick 8 the synchronized line must still be low, or the start is dropped and hunting resumes with no output.
- R5: Data bit i (i = 0..7) is sampled at tick 8+16*(i+1). The bits are assembled least significant bit first. rx_data changes only in the cycle rx_valid is high.
- R6: The stop bit is sampled at tick 152. At the clock edge of that tick, rx_valid goes high for exactly one cycle and rx_data takes the received byte.
- R7: If the stop sample is low, rx_frame_err is high in the same cycle as rx_valid. rx_frame_err is never high without rx_valid.
- R8: Hunting resumes from the tick after the stop sample. A start edge that comes before the end of a full-length stop bit is accepted, whether from a fast sender or a shortened stop bit.
- R9: The receiver changes state only on clock edges where tick16 is high. Line activity with no tick produces no output.
- R10: After a frame whose stop sample is low, a line that stays low does not start a new frame. The line must go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | Enable at sixteen times the baud rate |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte completes |
| rx_frame_err | output | 1 | Stop sample was low; high only with rx_valid |

## Verification
The receiver is fed back-to-back frames at the nominal rate and with a sender about three percent fast and three percent slow. The bytes include all-zero, all-one and alternating values, which separate bit order from timing drift across runs that have no transitions. Frames with a three-quarter stop bit show that the receiver accepts an early start edge. A short low glitch, a frame whose stop bit is low followed by a held-low line, and line toggling while the tick is halted each check that nothing comes out when nothing should.

// File: rtl/uart_rx_pkg.sv
// Shared types for the oversampling receiver.
// Assumes: state encoding is only used inside the receiver and its checker.
package uart_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
// Synchronizer chain bringing the asynchronous line into the clock domain.
// Assumes: idle line level is high, so the chain resets to all ones.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] chain_q;

    // shift the raw line through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_async};
    end

    assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_ctrl.sv
// Frame sequencer: hunts for start edges, times mid-bit samples in ticks.
// Assumes: tick arrives at OVS times the baud rate; one frame is
// start + DATA_BITS + one stop. Hunting resumes right after the stop sample.
module uart_rx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    output logic      sample_bit,
    output logic      sample_stop,
    output rx_state_e state_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bitn_q;
    logic              prev_q;
    logic              at_bit_end;

    assign at_bit_end  = tick && (cnt_q == CNT_LAST);
    assign sample_bit  = at_bit_end && (state_q == ST_DATA);
    assign sample_stop = at_bit_end && (state_q == ST_STOP);
    assign state_o     = state_q;

    // remember the line level seen at the previous tick for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line_s;
    end

    // advance the frame sequence on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            bitn_q  <= '0;
        end else if (tick) begin
            case (state_q)
                ST_HUNT: begin
                    if (prev_q && !line_s) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt_q == CNT_HALF) begin
                        cnt_q   <= '0;
                        bitn_q  <= '0;
                        state_q <= line_s ? ST_HUNT : ST_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (bitn_q == BIT_LAST) state_q <= ST_STOP;
                        else                    bitn_q  <= bitn_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_HUNT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_shift.sv
// Data path: collects sampled bits LSB first and issues the result.
// Assumes: sample strobes are single-cycle and never coincide.
module uart_rx_shift #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_s,
    input  logic                 sample_bit,
    input  logic                 sample_stop,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);
    logic [DATA_BITS-1:0] shreg_q;

    // shift each sampled data bit in from the top, so bit 0 ends lowest
    always_ff @(posedge clk) begin
        if (!rst_n)          shreg_q <= '0;
        else if (sample_bit) shreg_q <= {line_s, shreg_q[DATA_BITS-1:1]};
    end

    // publish the byte and the stop-bit verdict at the stop sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= sample_stop;
            ferr_o  <= sample_stop && !line_s;
            if (sample_stop) data_o <= shreg_q;
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
// Oversampling asynchronous receiver top: synchronizer, sequencer, data path.
// Assumes: tick16 is a one-cycle enable at OVS times the baud rate.
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 tick16,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    logic      line_s;
    logic      sample_bit;
    logic      sample_stop;
    rx_state_e fsm_state;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .line_async(rx_line), .line_sync(line_s)
    );

    uart_rx_ctrl #(.DATA_BITS(DATA_BITS), .OVS(OVS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line_s(line_s),
        .sample_bit(sample_bit), .sample_stop(sample_stop), .state_o(fsm_state)
    );

    uart_rx_shift #(.DATA_BITS(DATA_BITS)) shift_i (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .sample_bit(sample_bit), .sample_stop(sample_stop),
        .data_o(rx_data), .valid_o(rx_valid), .ferr_o(rx_frame_err)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
// Property checker for the receiver, attached to the top by bind.
module uart_os_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick16,
    input logic                 rx_valid,
    input logic                 rx_frame_err,
    input logic [DATA_BITS-1:0] rx_data,
    input logic [1:0]           st
);
    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    // R9
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick16));

    // R9
    state_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(st));

    // R3
    hunt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0) |=> (st == 2'd0 || st == 2'd1));
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_data(rx_data), .st(fsm_state)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic       tick_en = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int compared = 0;
    int mismatched = 0;
    int div = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_os_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    // tick every fourth clock: 64 clocks per bit nominal
    always @(negedge clk) begin
        if (tick_en) begin
            tick16 <= (div == 3);
            div    <= (div + 1) % 4;
        end else begin
            tick16 <= 1'b0;
        end
    end

    // behavioural reference: tick count since the start edge
    logic       d1 = 1, d2 = 1, vis, prevl = 1, m_valid = 0, m_err = 0;
    logic [7:0] m_data = 0, m_bits = 0;
    bit         active = 0;
    int         t = 0;

    always @(posedge clk) begin
        vis = d2; d2 = d1; d1 = rx_line;
        m_valid = 0; m_err = 0;
        started = 1;
        if (!rst_n) begin
            d1 = 1; d2 = 1; prevl = 1; active = 0; t = 0; m_data = 0; m_bits = 0;
        end else if (tick16) begin
            if (!active) begin
                if (prevl && !vis) begin active = 1; t = 0; end
            end else begin
                t++;
                if (t == 8) begin
                    if (vis) active = 0;
                end else if (t == 152) begin
                    m_valid = 1; m_err = !vis; m_data = m_bits; active = 0;
                end else if (t > 8 && (t - 8) % 16 == 0) begin
                    m_bits[(t - 8) / 16 - 1] = vis;
                end
            end
            prevl = vis;
        end
    end

    // per-cycle comparison and received-byte capture
    logic [8:0] got[$];
    always @(negedge clk) begin
        if (started && !done) begin
            compared++;
            if (rx_valid !== m_valid || rx_frame_err !== m_err || rx_data !== m_data) begin
                mismatched++;
                $display("FAIL R2/R3/R6 cycle: got v=%b e=%b d=%h exp v=%b e=%b d=%h",
                         rx_valid, rx_frame_err, rx_data, m_valid, m_err, m_data);
            end
            if (rx_valid) got.push_back({rx_frame_err, rx_data});
        end
    end

    task automatic drive(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int p, input int stop_n, input logic stop_v);
        drive(1'b0, p);
        for (int i = 0; i < 8; i++) drive(b[i], p);
        drive(stop_v, stop_n);
    endtask

    task automatic expect_bytes(input logic [8:0] exp[$], input string tag);
        compared++;
        if (got.size() != exp.size()) begin
            mismatched++;
            $display("FAIL %s count: actual %0d expected %0d", tag, got.size(), exp.size());
        end else begin
            for (int i = 0; i < exp.size(); i++) begin
                compared++;
                if (got[i] !== exp[i]) begin
                    mismatched++;
                    $display("FAIL %s byte %0d: actual %h expected %h", tag, i, got[i], exp[i]);
                end
            end
        end
        got.delete();
    endtask

    initial begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        // R1 reset state
        compared++;
        if (rx_valid !== 0 || rx_frame_err !== 0 || rx_data !== 0) begin
            mismatched++;
            $display("FAIL R1 reset: actual v=%b e=%b d=%h expected 0 0 00",
                     rx_valid, rx_frame_err, rx_data);
        end
        rst_n = 1;
        drive(1'b1, 200);

        // R5 R3 nominal rate, back to back, no-transition bytes included
        send(8'hA5, 64, 64, 1); send(8'h00, 64, 64, 1);
        send(8'hFF, 64, 64, 1); send(8'h3C, 64, 64, 1);
        drive(1'b1, 300);
        expect_bytes('{9'h0A5, 9'h000, 9'h0FF, 9'h03C}, "R5 nominal");

        // R8 fast sender, edges arrive before a full stop would end
        send(8'h81, 62, 62, 1); send(8'h7E, 62, 62, 1); send(8'h55, 62, 62, 1);
        drive(1'b1, 300);
        expect_bytes('{9'h081, 9'h07E, 9'h055}, "R8 fast");

        // R8 shortened stop bits
        send(8'hC3, 64, 48, 1); send(8'h18, 64, 48, 1); send(8'h01, 64, 48, 1);
        drive(1'b1, 300);
        expect_bytes('{9'h0C3, 9'h018, 9'h001}, "R8 short stop");

        // R5 slow sender
        send(8'h0F, 66, 66, 1); send(8'hF0, 66, 66, 1);
        drive(1'b1, 300);
        expect_bytes('{9'h00F, 9'h0F0}, "R5 slow");

        // R4 glitch shorter than half a bit
        drive(1'b0, 16);
        drive(1'b1, 800);
        expect_bytes('{}, "R4 glitch");

        // R7 R10 low stop, line stays low, then recovers
        send(8'h5A, 64, 64, 0);
        drive(1'b0, 1000);
        drive(1'b1, 400);
        expect_bytes('{9'h15A}, "R7 R10 framing");

        // R9 line activity with tick halted
        tick_en = 0;
        drive(1'b1, 8);
        drive(1'b0, 40);
        drive(1'b1, 20);
        tick_en = 1;
        drive(1'b1, 300);
        expect_bytes('{}, "R9 no tick");

        // recovery after all of the above
        send(8'h96, 64, 64, 1);
        drive(1'b1, 300);
        expect_bytes('{9'h096}, "R3 recovery");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule